// File: doc/BRIEF.md
# Programmable Down-Counting Event Timer

The block is a single-channel event timer for a low-rate, always-on time base. Software programs a start value of up to 64 bits through a 32-bit register bus, picks the counter width (32 or 64 bits) and picks single-shot or auto-reload operation. While enabled, the counter steps down by one on every pulse of a 32.768 kHz tick input that the block does not divide. When the count steps from 1 to 0, the block latches a pending flag and raises a level interrupt if that interrupt is enabled.

To use it, software first clears the enable bit. It then writes the low start word, then the high start word (zero when the counter runs at 32 bits), and finally writes the control word with the enable bit set together with the mode and width bits it wants. The running count can be read as two 32-bit words. Because the count can change between those two reads, a read of the low count word also stores the complete count in a pair of snapshot words, which give both halves as they stood at one instant.

Top module: `evt_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `irq` is low.
- R2: Word offsets (byte address bits [4:2]) are: start low 0x00, start high 0x04, count low 0x08, count high 0x0C, control 0x10, interrupt 0x14, snapshot low 0x18, snapshot high 0x1C. The start words read back what was written. Control bit 0 = auto-reload, bit 1 = enable, bit 16 = 64-bit width. All other control bits read 0.
- R3: A control write that sets bit 1 while enable is 0 loads the counter from the start words at that same clock edge. In 32-bit mode only the low start word is loaded.
- R4: While enabled, each clock with `tick` high lowers a count above 1 by exactly one. Without `tick`, or with enable clear, the count holds.
- R5: In auto-reload mode, a tick at count 1 is an expiry and reloads the counter from the start words, so it keeps running.
- R6: In single-shot mode, a tick at count 1 is an expiry, and the count then stays at 0.
- R7: Interrupt register bit 1 (pending) is set by every expiry, whatever the interrupt-enable bit holds.
- R8: Interrupt register bit 0 is the interrupt enable. Bit 2 reads pending AND enable, and the `irq` output carries the same value.
- R9: Writing the interrupt register with bit 3 set clears pending. Bit 3 always reads 0. If an expiry falls in the same cycle as the clear, pending stays set.
- R10: In 32-bit mode the count high word reads 0 and only the low word counts. In 64-bit mode the count borrows across the two words, and expiry needs the full 64-bit count to be 1.
- R11: Reading the count low word stores the full count in the two snapshot words at that edge.
- R12: Writing the start words while the timer runs leaves the current count unchanged. The new value takes effect at the next reload or re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse at 32.768 kHz, synchronous to clk |
| reg_addr | input | 5 | Byte address of the register |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (used to capture the snapshot) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Level interrupt: pending AND enable |

## Verification
The hardest case to create from the ports is an expiry that lands in exactly the cycle a clear is written. The bench drives the counter to 1 by counting tick pulses one by one. It then issues the write to the interrupt register with `tick` held high in that same bus cycle, so the two events meet at one edge. A second hard case is the borrow from the high count word into the low one, together with a snapshot taken across it. The bench loads a 64-bit value of 2^32+1. It then checks that a count of 2^32 does not raise pending, and reads the snapshot words after the low word has wrapped.

// File: rtl/evt_pkg.sv
// Package: shared register selectors and bit positions for the event timer.
// Assumes a 32-bit register bus and byte addresses decoded on bits [4:2].
package evt_pkg;

    typedef enum logic [2:0] {
        RS_START_LO = 3'd0,
        RS_START_HI = 3'd1,
        RS_COUNT_LO = 3'd2,
        RS_COUNT_HI = 3'd3,
        RS_CONTROL  = 3'd4,
        RS_INTR     = 3'd5,
        RS_SNAP_LO  = 3'd6,
        RS_SNAP_HI  = 3'd7
    } reg_sel_e;

    localparam int CTL_RELOAD_BIT = 0;
    localparam int CTL_ENABLE_BIT = 1;
    localparam int CTL_WIDE_BIT   = 16;

    localparam int INT_ENABLE_BIT = 0;
    localparam int INT_PEND_BIT   = 1;
    localparam int INT_MASKED_BIT = 2;
    localparam int INT_CLEAR_BIT  = 3;

endpackage

// File: rtl/evt_regfile.sv
// Module: evt_regfile
// Holds the start words, control bits, interrupt enable and count snapshot.
// Decodes bus writes into a start pulse and a clear request, and drives the
// combinational read mux. Assumes the count input already reads 0 in its
// upper word when the counter runs at 32 bits.
module evt_regfile
    import evt_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int CNT_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  reg_sel_e          reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              pend,
    input  logic              irq_lvl,
    output logic [WORD_W-1:0] reg_rdata,
    output logic [CNT_W-1:0]  start_val,
    output logic              ctl_reload,
    output logic              ctl_enable,
    output logic              ctl_wide,
    output logic              int_enable,
    output logic              start_pls,
    output logic              start_wide,
    output logic              clr_req
);

    logic [WORD_W-1:0] start_lo_q, start_hi_q;
    logic [CNT_W-1:0]  snap_q;
    logic              wr_ctl, wr_int;

    // Decode: strobes for the control and interrupt registers.
    assign wr_ctl = reg_wr && (reg_sel == RS_CONTROL);
    assign wr_int = reg_wr && (reg_sel == RS_INTR);

    // Start pulse: enable goes from 0 to 1 through a control write.
    assign start_pls  = wr_ctl && reg_wdata[CTL_ENABLE_BIT] && !ctl_enable;
    assign start_wide = reg_wdata[CTL_WIDE_BIT];
    assign clr_req    = wr_int && reg_wdata[INT_CLEAR_BIT];
    assign start_val  = {start_hi_q, start_lo_q};

    // Start words: written from the bus, used only at load or reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_lo_q <= '0;
            start_hi_q <= '0;
        end else if (reg_wr) begin
            if (reg_sel == RS_START_LO) start_lo_q <= reg_wdata;
            if (reg_sel == RS_START_HI) start_hi_q <= reg_wdata;
        end
    end

    // Control bits: mode, enable and width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_reload <= 1'b0;
            ctl_enable <= 1'b0;
            ctl_wide   <= 1'b0;
        end else if (wr_ctl) begin
            ctl_reload <= reg_wdata[CTL_RELOAD_BIT];
            ctl_enable <= reg_wdata[CTL_ENABLE_BIT];
            ctl_wide   <= reg_wdata[CTL_WIDE_BIT];
        end
    end

    // Interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      int_enable <= 1'b0;
        else if (wr_int) int_enable <= reg_wdata[INT_ENABLE_BIT];
    end

    // Snapshot: the full count, captured when the low count word is read.
    always_ff @(posedge clk) begin
        if (!rst_n)                              snap_q <= '0;
        else if (reg_rd && reg_sel == RS_COUNT_LO) snap_q <= cnt_val;
    end

    // Read mux: selects the addressed word; unused bits read 0.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            RS_START_LO: reg_rdata = start_lo_q;
            RS_START_HI: reg_rdata = start_hi_q;
            RS_COUNT_LO: reg_rdata = cnt_val[WORD_W-1:0];
            RS_COUNT_HI: reg_rdata = cnt_val[CNT_W-1:WORD_W];
            RS_CONTROL: begin
                reg_rdata[CTL_RELOAD_BIT] = ctl_reload;
                reg_rdata[CTL_ENABLE_BIT] = ctl_enable;
                reg_rdata[CTL_WIDE_BIT]   = ctl_wide;
            end
            RS_INTR: begin
                reg_rdata[INT_ENABLE_BIT] = int_enable;
                reg_rdata[INT_PEND_BIT]   = pend;
                reg_rdata[INT_MASKED_BIT] = irq_lvl;
            end
            RS_SNAP_LO:  reg_rdata = snap_q[WORD_W-1:0];
            RS_SNAP_HI:  reg_rdata = snap_q[CNT_W-1:WORD_W];
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/evt_counter.sv
// Module: evt_counter
// The down counter. Loads on a start pulse, steps on each tick while
// enabled, and flags expiry on the step from 1 to 0. In 32-bit mode the
// upper word is forced to 0 so the count and its compare stay 32-bit.
// Assumes tick is a one-cycle pulse synchronous to clk.
module evt_counter #(
    parameter int WORD_W = 32,
    localparam int CNT_W = 2 * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic             reload_mode,
    input  logic             wide,
    input  logic             start_pls,
    input  logic             start_wide,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] cnt_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_val, first_val;
    logic             at_one, step;

    // Width view: mask the upper word whenever the narrow width is selected.
    assign cnt_val    = wide ? cnt_q : {{WORD_W{1'b0}}, cnt_q[WORD_W-1:0]};
    assign reload_val = wide ? start_val : {{WORD_W{1'b0}}, start_val[WORD_W-1:0]};
    assign first_val  = start_wide ? start_val
                                   : {{WORD_W{1'b0}}, start_val[WORD_W-1:0]};

    // Step and expiry qualifiers; a start pulse takes priority over a tick.
    assign at_one = (cnt_val == CNT_W'(1));
    assign step   = enable && tick && !start_pls && (cnt_val != '0);
    assign expire = step && at_one;

    // Count register: load, reload, decrement or hold at the masked value.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (start_pls)  cnt_q <= first_val;
        else if (expire)     cnt_q <= reload_mode ? reload_val : '0;
        else if (step)       cnt_q <= cnt_val - CNT_W'(1);
        else                 cnt_q <= cnt_val;
    end

endmodule

// File: rtl/evt_irq.sv
// Module: evt_irq
// Pending flag and interrupt level. Expiry sets the flag and a clear
// request resets it; expiry wins if both arrive in one cycle.
module evt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_req,
    input  logic int_enable,
    output logic pend,
    output logic irq_lvl
);

    // Pending flag with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend <= 1'b0;
        else if (expire)  pend <= 1'b1;
        else if (clr_req) pend <= 1'b0;
    end

    // Interrupt level gated by the enable bit.
    assign irq_lvl = pend && int_enable;

endmodule

// File: rtl/evt_timer.sv
// Module: evt_timer (top)
// Single-channel programmable event timer on a 32-bit register bus.
// Assumes reg_addr is word-aligned; bits [1:0] are ignored.
module evt_timer
    import evt_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq
);

    localparam int CNT_W = 2 * WORD_W;

    reg_sel_e         reg_sel;
    logic [CNT_W-1:0] cnt_val, start_val;
    logic             ctl_reload, ctl_enable, ctl_wide, int_enable;
    logic             start_pls, start_wide, clr_req, expire, pend;
    logic             unused_addr_lsb;

    // Word select from the byte address.
    assign reg_sel         = reg_sel_e'(reg_addr[4:2]);
    assign unused_addr_lsb = ^{reg_addr[1:0]};

    evt_regfile #(.WORD_W(WORD_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .cnt_val    (cnt_val),
        .pend       (pend),
        .irq_lvl    (irq),
        .reg_rdata  (reg_rdata),
        .start_val  (start_val),
        .ctl_reload (ctl_reload),
        .ctl_enable (ctl_enable),
        .ctl_wide   (ctl_wide),
        .int_enable (int_enable),
        .start_pls  (start_pls),
        .start_wide (start_wide),
        .clr_req    (clr_req)
    );

    evt_counter #(.WORD_W(WORD_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .enable      (ctl_enable),
        .reload_mode (ctl_reload),
        .wide        (ctl_wide),
        .start_pls   (start_pls),
        .start_wide  (start_wide),
        .start_val   (start_val),
        .cnt_val     (cnt_val),
        .expire      (expire)
    );

    evt_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .clr_req    (clr_req),
        .int_enable (int_enable),
        .pend       (pend),
        .irq_lvl    (irq)
    );

endmodule

// File: rtl/evt_timer_chk.sv
// Module: evt_timer_chk
// Temporal checks for evt_timer, attached by bind below.
module evt_timer_chk #(
    parameter int WORD_W = 32,
    localparam int CNT_W = 2 * WORD_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             reg_wr,
    input logic [4:0]       reg_addr,
    input logic [WORD_W-1:0] reg_wdata,
    input logic             irq,
    input logic             start_pls,
    input logic             expire,
    input logic             clr_req,
    input logic             ctl_enable,
    input logic             ctl_reload,
    input logic             pend,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] start_val
);

    logic ctl_write, ie_set, unused_chk;
    assign ctl_write  = reg_wr && (reg_addr[4:2] == 3'd4);
    assign ie_set     = reg_wr && (reg_addr[4:2] == 3'd5) && reg_wdata[0];
    assign unused_chk = ^{reg_wdata, reg_addr[1:0], start_val[CNT_W-1:WORD_W]};

    // R3: a start pulse loads the low start word
    a_r3_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        start_pls |=> cnt_val[WORD_W-1:0] == $past(start_val[WORD_W-1:0]));

    // R4: one tick lowers a count above 1 by exactly one
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_enable && tick && !start_pls && !ctl_write && cnt_val > CNT_W'(1))
        |=> cnt_val == $past(cnt_val) - CNT_W'(1));

    // R5: auto-reload restarts from the start words
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctl_reload)
        |=> cnt_val[WORD_W-1:0] == $past(start_val[WORD_W-1:0]));

    // R6: single-shot count rests at zero
    a_r6_rest_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_enable && !ctl_reload && cnt_val == '0 && !start_pls)
        |=> cnt_val == '0);

    // R7: every expiry leaves pending set
    a_r7_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pend);

    // R9: a clear without a simultaneous expiry drops pending
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !expire) |=> !pend);

    // R8: irq only rises after an expiry or an enable write
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(expire) || $past(ie_set)));

endmodule

bind evt_timer evt_timer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr[4:0]),
    .reg_wdata  (reg_wdata),
    .irq        (irq),
    .start_pls  (start_pls),
    .expire     (expire),
    .clr_req    (clr_req),
    .ctl_enable (ctl_enable),
    .ctl_reload (ctl_reload),
    .pend       (pend),
    .cnt_val    (cnt_val),
    .start_val  (start_val)
);

// File: tb/sim_evt_timer.sv
module sim_evt_timer;

    localparam logic [4:0] A_SLO = 5'h00, A_SHI = 5'h04, A_CLO = 5'h08,
                           A_CHI = 5'h0C, A_CTL = 5'h10, A_INT = 5'h14,
                           A_NLO = 5'h18, A_NHI = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    evt_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // Monitor: pops one expected item per slot, in the low clock phase.
    always begin
        @(negedge clk);
        #2;
        if (sb.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it  = sb.pop_front();
            got = it.is_irq ? {31'b0, irq} : reg_rdata;
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s actual %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d, input bit tk = 0);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; reg_rd = 1'b0; tick = tk;
        @(posedge clk); #1;
        reg_wr = 1'b0; tick = 1'b0;
    endtask

    task automatic expect_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1; reg_wr = 1'b0; tick = 1'b0;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic expect_irq(input bit e, input string tag);
        item_t it;
        @(negedge clk);
        reg_rd = 1'b0; reg_wr = 1'b0; tick = 1'b0;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sb.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            reg_wr = 1'b0; reg_rd = 1'b0; tick = 1'b1;
            @(posedge clk); #1;
            tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            summary();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        expect_rd(A_SLO, 32'h0, "R1 start lo");
        expect_rd(A_SHI, 32'h0, "R1 start hi");
        expect_rd(A_CHI, 32'h0, "R1 count hi");
        expect_rd(A_CTL, 32'h0, "R1 control");
        expect_rd(A_INT, 32'h0, "R1 intr");
        expect_rd(A_NLO, 32'h0, "R1 snap lo");
        expect_rd(A_NHI, 32'h0, "R1 snap hi");
        expect_irq(1'b0, "R1 irq");

        // Single-shot, 32-bit, start 5
        bus_wr(A_SLO, 32'd5);
        bus_wr(A_SHI, 32'd0);
        expect_rd(A_SLO, 32'd5, "R2 start lo readback");
        bus_wr(A_CTL, 32'h2);
        expect_rd(A_CTL, 32'h2, "R2 control readback");
        expect_rd(A_CLO, 32'd5, "R3 loaded on enable");
        idle(3);
        expect_rd(A_CLO, 32'd5, "R4 holds without tick");
        ticks(2);
        expect_rd(A_CLO, 32'd3, "R4 two ticks");
        ticks(3);
        expect_rd(A_INT, 32'h2, "R7 pending without enable");
        expect_irq(1'b0, "R8 irq masked");
        ticks(2);
        expect_rd(A_CLO, 32'd0, "R6 rests at zero");

        // Interrupt enable and clear
        bus_wr(A_INT, 32'h1);
        expect_rd(A_INT, 32'h7, "R8 masked status");
        expect_irq(1'b1, "R8 irq high");
        bus_wr(A_INT, 32'h9);
        expect_rd(A_INT, 32'h1, "R9 cleared, clear bit reads 0");
        expect_irq(1'b0, "R9 irq low after clear");

        // Auto-reload, start 3
        bus_wr(A_CTL, 32'h0);
        bus_wr(A_SLO, 32'd3);
        bus_wr(A_CTL, 32'h3);
        ticks(3);
        expect_rd(A_CLO, 32'd3, "R5 reloaded");
        expect_rd(A_INT, 32'h7, "R7 pending after reload expiry");
        bus_wr(A_INT, 32'h9);
        ticks(1);
        bus_wr(A_SLO, 32'd10);
        expect_rd(A_CLO, 32'd2, "R12 running count untouched");
        ticks(2);
        expect_rd(A_CLO, 32'd10, "R12 new start at reload");

        // Clear and expiry in one cycle
        bus_wr(A_INT, 32'h9);
        ticks(9);
        expect_rd(A_CLO, 32'd1, "R4 at one");
        bus_wr(A_INT, 32'h9, 1'b1);
        expect_rd(A_INT, 32'h7, "R9 expiry wins over clear");
        expect_irq(1'b1, "R9 irq stays");

        // 64-bit borrow and snapshot
        bus_wr(A_CTL, 32'h0);
        bus_wr(A_SLO, 32'd1);
        bus_wr(A_SHI, 32'd1);
        bus_wr(A_CTL, 32'h0001_0002);
        expect_rd(A_CHI, 32'd1, "R10 wide high loaded");
        expect_rd(A_CLO, 32'd1, "R10 wide low loaded");
        bus_wr(A_INT, 32'h8);
        ticks(1);
        expect_rd(A_INT, 32'h0, "R10 no expiry at 2^32");
        expect_rd(A_CLO, 32'd0, "R10 low word zero");
        ticks(1);
        expect_rd(A_CHI, 32'd0, "R10 borrow into low");
        expect_rd(A_NHI, 32'd1, "R11 snapshot high");
        expect_rd(A_NLO, 32'd0, "R11 snapshot low");
        expect_rd(A_CLO, 32'hFFFF_FFFF, "R10 low after borrow");

        // 32-bit mode ignores the high start word
        bus_wr(A_CTL, 32'h0);
        bus_wr(A_SHI, 32'd7);
        bus_wr(A_SLO, 32'd4);
        bus_wr(A_CTL, 32'h2);
        expect_rd(A_SHI, 32'd7, "R2 start hi readback");
        expect_rd(A_CHI, 32'd0, "R10 narrow high reads 0");
        expect_rd(A_CLO, 32'd4, "R3 narrow load");

        // Unused control bits read 0
        bus_wr(A_CTL, 32'h0);
        bus_wr(A_CTL, 32'hFFFF_FFFD);
        expect_rd(A_CTL, 32'h0001_0001, "R2 control unused bits");

        idle(3);
        done = 1;
        summary();
    end

endmodule